// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings a DDR3 SDRAM from power-on to an operational state on behalf of a memory controller. After a start pulse it holds the memory reset line low, then keeps clock enable low, and then raises clock enable and puts the on-die termination control at a fixed level. After the exit delay it writes the four mode registers in the order the device requires. It follows them with a long ZQ calibration. It then waits until both the DLL lock time and the calibration time have elapsed before it reports the memory ready.

The controller supplies the contents of the four mode registers on ports. The sequencer overrides only the bits that this sequence needs: DLL enable in MR1 and DLL reset in MR0. All waits are clock-cycle parameters. Each command lasts a single clock cycle. A no-operation command is driven in every other cycle, so two commands are never back to back.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, the outputs are as follows. `ddr_reset_n`, `ddr_cke`, `ddr_odt` and `init_done` are 0. The command is NOP, encoded {cs_n,ras_n,cas_n,we_n} = 4'b0111. `ddr_ba` and `ddr_addr` are 0.
- R2: A `start` sampled high in the idle state makes `ddr_reset_n` rise exactly T_RESET clocks after that edge. Without `start`, `ddr_reset_n` stays low.
- R3: `ddr_cke` rises exactly T_CKE clocks after `ddr_reset_n` rises. Once high, it stays high until `rst_n` is applied. It is never high while `ddr_reset_n` is low.
- R4: `ddr_odt` is 0 while `ddr_cke` is 0. It takes the value ODT_INIT_LEVEL in the same cycle that `ddr_cke` rises and stays constant from then on.
- R5: The first mode-register write occurs exactly T_XPR clocks after `ddr_cke` rises. A mode-register write is encoded {cs_n,ras_n,cas_n,we_n} = 4'b0000.
- R6: The four mode-register writes target MR2, MR3, MR1 and MR0, in that order, and are spaced T_MRD clocks apart. `ddr_ba` carries the register number: 3'b010, 3'b011, 3'b001 and 3'b000.
- R7: During a mode-register write, `ddr_addr` equals the matching `mrN_cfg` port. There are two exceptions: bit 0 is forced to 0 for MR1 (DLL on), and bit 8 is forced to 1 for MR0 (DLL reset).
- R8: Exactly T_MOD clocks after the MR0 write, a long ZQ calibration is issued. It is encoded {cs_n,ras_n,cas_n,we_n} = 4'b0110, with `ddr_addr` bit 10 set, all other address bits 0 and `ddr_ba` = 0.
- R9: `init_done` rises exactly at max(MR0 cycle + T_DLLK, ZQ cycle + T_ZQINIT) and then stays high.
- R10: Every cycle without a scheduled command drives NOP with `ddr_ba` = 0 and `ddr_addr` = 0. No command directly follows another command.
- R11: `start` is ignored while a sequence is running and after `init_done` is set. The timeline and outputs do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer |
| start | input | 1 | Begins the power-up sequence when idle |
| mr0_cfg | input | ADDR_W | Payload for MR0 |
| mr1_cfg | input | ADDR_W | Payload for MR1 |
| mr2_cfg | input | ADDR_W | Payload for MR2 |
| mr3_cfg | input | ADDR_W | Payload for MR3 |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ADDR_W | Address bus |
| ddr_cke | output | 1 | Clock enable to the memory |
| ddr_odt | output | 1 | Termination control to the memory |
| ddr_reset_n | output | 1 | Memory reset, active low |
| init_done | output | 1 | Initialization complete |

## Verification
The bench shrinks every wait to a handful of clocks: reset hold 7, CKE hold 5, exit delay 3, MRD 4, MOD 6. This keeps a whole sequence under sixty cycles, so every output can be compared against an arithmetic timeline on every cycle. Two instances run side by side. One has DLL lock 20 and calibration 10, so the DLL wait governs ready. The other has 8 and 12, so the calibration wait governs it. ODT_INIT_LEVEL is set to 1 so that the termination edge is visible. Payloads of all ones, all zeros and a mixed pattern cover both forced DLL bits. Stray start pulses during and after the sequence exercise the ignore rule.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_CKE,
        ST_XPR,
        ST_MRS,
        ST_MOD,
        ST_CAL,
        ST_DONE
    } seq_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    localparam cmd_t CMD_NOP  = 4'b0111;
    localparam cmd_t CMD_MRS  = 4'b0000;
    localparam cmd_t CMD_ZQCL = 4'b0110;

    localparam int MRS_STEPS   = 4;
    localparam int DLL_EN_BIT  = 0;
    localparam int DLL_RST_BIT = 8;
    localparam int ZQ_LONG_BIT = 10;

    // Step of the write sequence -> mode register number
    function automatic logic [1:0] mrs_target(input logic [1:0] step);
        case (step)
            2'd0:    return 2'd2;
            2'd1:    return 2'd3;
            2'd2:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr3_init_cnt.sv
module ddr3_init_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

    // An elapsed wait never wraps into a new one unless reloaded
    assert_cnt_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/ddr3_init_mrs_sel.sv
module ddr3_init_mrs_sel
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BA_W   = 3
) (
    input  logic [1:0]        step,
    input  logic [ADDR_W-1:0] mr0_val,
    input  logic [ADDR_W-1:0] mr1_val,
    input  logic [ADDR_W-1:0] mr2_val,
    input  logic [ADDR_W-1:0] mr3_val,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] pay [MRS_STEPS];
    logic [1:0]        tgt;

    assign pay[0] = mr0_val;
    assign pay[1] = mr1_val;
    assign pay[2] = mr2_val;
    assign pay[3] = mr3_val;

    assign tgt = mrs_target(step);
    assign ba  = BA_W'(tgt);

    always_comb begin
        addr = pay[tgt];
        if (tgt == 2'd1) begin
            addr[DLL_EN_BIT] = 1'b0;
        end
        if (tgt == 2'd0) begin
            addr[DLL_RST_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W         = 14,
    parameter int BA_W           = 3,
    parameter int T_RESET        = 10000,
    parameter int T_CKE          = 25000,
    parameter int T_XPR          = 5,
    parameter int T_MRD          = 4,
    parameter int T_MOD          = 12,
    parameter int T_DLLK         = 512,
    parameter int T_ZQINIT       = 512,
    parameter bit ODT_INIT_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] mr0_cfg,
    input  logic [ADDR_W-1:0] mr1_cfg,
    input  logic [ADDR_W-1:0] mr2_cfg,
    input  logic [ADDR_W-1:0] mr3_cfg,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [BA_W-1:0]   ddr_ba,
    output logic [ADDR_W-1:0] ddr_addr,
    output logic              ddr_cke,
    output logic              ddr_odt,
    output logic              ddr_reset_n,
    output logic              init_done
);

    localparam int T_MAX = max_i(max_i(max_i(T_RESET, T_CKE), max_i(T_XPR, T_MRD)),
                                 max_i(max_i(T_MOD, T_DLLK), T_ZQINIT));
    localparam int CW    = $clog2(T_MAX + 1);

    typedef struct packed {
        seq_state_t        state;
        logic [1:0]        step;
        cmd_t              cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              cke;
        logic              rstn;
        logic              odt;
        logic              ready;
    } regs_t;

    regs_t r_d, r_q;

    logic          ph_load, dll_load, zq_load;
    logic [CW-1:0] ph_val;
    logic          ph_zero, dll_zero, zq_zero;
    logic [BA_W-1:0]   sel_ba;
    logic [ADDR_W-1:0] sel_addr;

    ddr3_init_cnt #(.W(CW)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
    );

    ddr3_init_cnt #(.W(CW)) u_dll (
        .clk(clk), .rst_n(rst_n), .load(dll_load), .load_val(CW'(T_DLLK - 1)), .zero(dll_zero)
    );

    ddr3_init_cnt #(.W(CW)) u_zq (
        .clk(clk), .rst_n(rst_n), .load(zq_load), .load_val(CW'(T_ZQINIT - 1)), .zero(zq_zero)
    );

    ddr3_init_mrs_sel #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_sel (
        .step(r_q.step),
        .mr0_val(mr0_cfg), .mr1_val(mr1_cfg), .mr2_val(mr2_cfg), .mr3_val(mr3_cfg),
        .ba(sel_ba), .addr(sel_addr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.cmd  = CMD_NOP;
        r_d.ba   = '0;
        r_d.addr = '0;
        ph_load  = 1'b0;
        ph_val   = '0;
        dll_load = 1'b0;
        zq_load  = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_RST;
                    ph_load   = 1'b1;
                    ph_val    = CW'(T_RESET - 1);
                end
            end
            ST_RST: begin
                if (ph_zero) begin
                    r_d.rstn  = 1'b1;
                    r_d.state = ST_CKE;
                    ph_load   = 1'b1;
                    ph_val    = CW'(T_CKE - 1);
                end
            end
            ST_CKE: begin
                if (ph_zero) begin
                    r_d.cke   = 1'b1;
                    r_d.odt   = ODT_INIT_LEVEL;
                    r_d.state = ST_XPR;
                    r_d.step  = 2'd0;
                    ph_load   = 1'b1;
                    ph_val    = CW'(T_XPR - 1);
                end
            end
            ST_XPR: begin
                if (ph_zero) begin
                    r_d.cmd   = CMD_MRS;
                    r_d.ba    = sel_ba;
                    r_d.addr  = sel_addr;
                    r_d.step  = 2'd1;
                    r_d.state = ST_MRS;
                    ph_load   = 1'b1;
                    ph_val    = CW'(T_MRD - 1);
                end
            end
            ST_MRS: begin
                if (ph_zero) begin
                    r_d.cmd  = CMD_MRS;
                    r_d.ba   = sel_ba;
                    r_d.addr = sel_addr;
                    ph_load  = 1'b1;
                    if (r_q.step == 2'(MRS_STEPS - 1)) begin
                        r_d.state = ST_MOD;
                        ph_val    = CW'(T_MOD - 1);
                        dll_load  = 1'b1;
                    end else begin
                        r_d.step = r_q.step + 2'd1;
                        ph_val   = CW'(T_MRD - 1);
                    end
                end
            end
            ST_MOD: begin
                if (ph_zero) begin
                    r_d.cmd               = CMD_ZQCL;
                    r_d.addr[ZQ_LONG_BIT] = 1'b1;
                    r_d.state             = ST_CAL;
                    zq_load               = 1'b1;
                end
            end
            ST_CAL: begin
                if (dll_zero && zq_zero) begin
                    r_d.ready = 1'b1;
                    r_d.state = ST_DONE;
                end
            end
            default: begin
                r_d.state = ST_DONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.cmd   <= CMD_NOP;
        end else begin
            r_q <= r_d;
        end
    end

    assign ddr_cs_n    = r_q.cmd.cs_n;
    assign ddr_ras_n   = r_q.cmd.ras_n;
    assign ddr_cas_n   = r_q.cmd.cas_n;
    assign ddr_we_n    = r_q.cmd.we_n;
    assign ddr_ba      = r_q.ba;
    assign ddr_addr    = r_q.addr;
    assign ddr_cke     = r_q.cke;
    assign ddr_odt     = r_q.odt;
    assign ddr_reset_n = r_q.rstn;
    assign init_done   = r_q.ready;

    logic cmd_active, mrs_issue;
    assign cmd_active = ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} != 4'b0111);
    assign mrs_issue  = ({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} == 4'b0000);

    assert_rstn_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ddr_reset_n |=> ddr_reset_n);

    assert_cke_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ddr_cke |=> ddr_cke);

    assert_cke_after_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ddr_cke |-> ddr_reset_n);

    assert_odt_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ddr_cke |-> !ddr_odt);

    assert_odt_static_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ddr_cke |=> $stable(ddr_odt));

    assert_mrs_cke_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mrs_issue |-> (ddr_cke && !init_done));

    assert_mr1_dll_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_issue && ddr_ba == BA_W'(1)) |-> !ddr_addr[DLL_EN_BIT]);

    assert_ready_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_cmd_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_active |=> !cmd_active);

endmodule

// File: tb/tb_ddr3_init_seq.sv
module tb_ddr3_init_seq;

    localparam int AW     = 14;
    localparam int BW     = 3;
    localparam int TR     = 7;
    localparam int TC     = 5;
    localparam int TX     = 3;
    localparam int TMRD   = 4;
    localparam int TMOD   = 6;
    localparam int DLLK_A = 20;
    localparam int ZQ_A   = 10;
    localparam int DLLK_B = 8;
    localparam int ZQ_B   = 12;

    localparam int K_MR2 = TR + TC + TX;
    localparam int K_MR3 = K_MR2 + TMRD;
    localparam int K_MR1 = K_MR2 + 2 * TMRD;
    localparam int K_MR0 = K_MR2 + 3 * TMRD;
    localparam int K_ZQ  = K_MR0 + TMOD;
    localparam int K_RDA = (K_MR0 + DLLK_A > K_ZQ + ZQ_A) ? K_MR0 + DLLK_A : K_ZQ + ZQ_A;
    localparam int K_RDB = (K_MR0 + DLLK_B > K_ZQ + ZQ_B) ? K_MR0 + DLLK_B : K_ZQ + ZQ_B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] mr0, mr1, mr2, mr3;
    logic cs_n, ras_n, cas_n, we_n, cke, odt, drst_n, done;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;
    logic b_cs_n, b_ras_n, b_cas_n, b_we_n, b_cke, b_odt, b_rst_n, b_done;
    logic [BW-1:0] b_ba;
    logic [AW-1:0] b_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ddr3_init_seq #(.ADDR_W(AW), .BA_W(BW), .T_RESET(TR), .T_CKE(TC), .T_XPR(TX),
        .T_MRD(TMRD), .T_MOD(TMOD), .T_DLLK(DLLK_A), .T_ZQINIT(ZQ_A),
        .ODT_INIT_LEVEL(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mr0_cfg(mr0), .mr1_cfg(mr1), .mr2_cfg(mr2), .mr3_cfg(mr3),
        .ddr_cs_n(cs_n), .ddr_ras_n(ras_n), .ddr_cas_n(cas_n), .ddr_we_n(we_n),
        .ddr_ba(ba), .ddr_addr(addr), .ddr_cke(cke), .ddr_odt(odt),
        .ddr_reset_n(drst_n), .init_done(done));

    ddr3_init_seq #(.ADDR_W(AW), .BA_W(BW), .T_RESET(TR), .T_CKE(TC), .T_XPR(TX),
        .T_MRD(TMRD), .T_MOD(TMOD), .T_DLLK(DLLK_B), .T_ZQINIT(ZQ_B),
        .ODT_INIT_LEVEL(1'b1)) dut_zq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mr0_cfg(mr0), .mr1_cfg(mr1), .mr2_cfg(mr2), .mr3_cfg(mr3),
        .ddr_cs_n(b_cs_n), .ddr_ras_n(b_ras_n), .ddr_cas_n(b_cas_n), .ddr_we_n(b_we_n),
        .ddr_ba(b_ba), .ddr_addr(b_addr), .ddr_cke(b_cke), .ddr_odt(b_odt),
        .ddr_reset_n(b_rst_n), .init_done(b_done));

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check_idle_outputs(input string req);
        chk(req, "cmd", 32'({cs_n, ras_n, cas_n, we_n}), 32'h7);
        chk(req, "ba", 32'(ba), 32'h0);
        chk(req, "addr", 32'(addr), 32'h0);
        chk(req, "reset_n", 32'(drst_n), 32'h0);
        chk(req, "cke", 32'(cke), 32'h0);
        chk(req, "odt", 32'(odt), 32'h0);
        chk(req, "done", 32'(done), 32'h0);
        chk(req, "done_b", 32'(b_done), 32'h0);
    endtask

    // R1: reset state, during and just after reset
    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_idle_outputs("R1");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_idle_outputs("R1");
    endtask

    // Compare every output against the arithmetic timeline at cycle k
    task automatic check_cycle(input int k, input logic [AW-1:0] p0, input logic [AW-1:0] p1,
                               input logic [AW-1:0] p2, input logic [AW-1:0] p3);
        logic [3:0]    e_cmd;
        logic [BW-1:0] e_ba;
        logic [AW-1:0] e_addr;
        string         rc, ra;
        e_cmd = 4'b0111; e_ba = '0; e_addr = '0; rc = "R10"; ra = "R10";
        if (k == K_MR2) begin
            e_cmd = 4'b0000; e_ba = 3'b010; e_addr = p2; rc = "R5"; ra = "R7";
        end else if (k == K_MR3) begin
            e_cmd = 4'b0000; e_ba = 3'b011; e_addr = p3; rc = "R6"; ra = "R7";
        end else if (k == K_MR1) begin
            e_cmd = 4'b0000; e_ba = 3'b001; e_addr = p1 & ~AW'(1); rc = "R6"; ra = "R7";
        end else if (k == K_MR0) begin
            e_cmd = 4'b0000; e_ba = 3'b000; e_addr = p0 | AW'(256); rc = "R6"; ra = "R7";
        end else if (k == K_ZQ) begin
            e_cmd = 4'b0110; e_ba = 3'b000; e_addr = AW'(1024); rc = "R8"; ra = "R8";
        end
        chk(rc, $sformatf("cmd k=%0d", k), 32'({cs_n, ras_n, cas_n, we_n}), 32'(e_cmd));
        chk(rc, $sformatf("ba k=%0d", k), 32'(ba), 32'(e_ba));
        chk(ra, $sformatf("addr k=%0d", k), 32'(addr), 32'(e_addr));
        chk("R2", $sformatf("reset_n k=%0d", k), 32'(drst_n), 32'(k >= TR));
        chk("R3", $sformatf("cke k=%0d", k), 32'(cke), 32'(k >= TR + TC));
        chk("R4", $sformatf("odt k=%0d", k), 32'(odt), 32'(k >= TR + TC));
        chk("R9", $sformatf("done k=%0d", k), 32'(done), 32'(k >= K_RDA));
        chk("R9", $sformatf("done_b k=%0d", k), 32'(b_done), 32'(k >= K_RDB));
    endtask

    // One full sequence; stray start pulses at k = s1 and s2 must be ignored (R11)
    task automatic run_seq(input logic [AW-1:0] p0, input logic [AW-1:0] p1,
                           input logic [AW-1:0] p2, input logic [AW-1:0] p3,
                           input int s1, input int s2);
        @(negedge clk);
        mr0 = p0; mr1 = p1; mr2 = p2; mr3 = p3;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= K_RDA + 3; k++) begin
            check_cycle(k, p0, p1, p2, p3);
            start = (k == s1 || k == s2);
            @(posedge clk);
            @(negedge clk);
        end
        // R11: start held high after completion changes nothing
        start = 1'b1;
        for (int j = 0; j < 6; j++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R11", "done after start", 32'(done), 32'h1);
            chk("R11", "cmd after start", 32'({cs_n, ras_n, cas_n, we_n}), 32'h7);
            chk("R11", "cke after start", 32'(cke), 32'h1);
        end
        start = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected sequence completion");
            summary();
            $finish;
        end
    end

    initial begin
        mr0 = '0; mr1 = '0; mr2 = '0; mr3 = '0;
        apply_reset();
        // R2: no start, reset line stays low
        for (int j = 0; j < TR + 3; j++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R2", "idle reset_n", 32'(drst_n), 32'h0);
            chk("R3", "idle cke", 32'(cke), 32'h0);
        end
        run_seq(14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h3FFF, 2, K_MR3 + 1);
        apply_reset();
        run_seq(14'h0000, 14'h0000, 14'h0000, 14'h0000, TR, K_ZQ);
        apply_reset();
        run_seq(14'h1234, 14'h0A55, 14'h2C3E, 14'h0005, 0, K_MR0 + 1);
        // R1: reset in the middle of a sequence returns to the reset state
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (K_MR1) @(posedge clk);
        apply_reset();
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule